// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a set of 8-bit general-purpose input ports and turns pin activity into interrupt requests. Every pin is configured on its own: it can react to a level or to a transition, and it can be set to the high level / rising transition or to the low level / falling transition. A transition that matches the configuration is held in a per-pin latch until software acknowledges it by writing a one to that pin's bit in the acknowledge register. A level-sensitive pin stays pending for as long as its input stays at the selected level.

The pins arrive asynchronously and pass through a two-stage synchroniser before any detection. Configuration is written through a simple one-cycle write port that selects a port and one of four per-port registers. The pending and enabled state of any port is read back combinationally through a status port. All ports except the last are combined into one shared interrupt line. Each pin of the last port drives its own interrupt line.

Top module: `pin_event_irq`

## Requirements
- R1: After reset every pin is level-sensitive, low-polarity and disabled, no edge is latched, and the status readout, the shared line and all per-pin lines are 0.
- R2: Global pin number n is bit n of `pins_i`. It belongs to port n/8, bit n%8. `cfg_port_i` and `stat_port_i` select that port.
- R3: `cfg_sel_i` selects the target register of a write: 0 is the trigger kind (bit 1 = edge, 0 = level), 1 is the polarity (bit 1 = high/rising, 0 = low/falling), 2 is the enable and 3 is the acknowledge. A write takes effect at the clock edge on which `cfg_we_i` is sampled high.
- R4: An enabled level-sensitive pin is pending whenever its synchronised input equals its polarity bit. This state shows two clock edges after the input changes and clears the same way. Acknowledge writes do not affect it.
- R5: An enabled edge-sensitive pin latches a transition in the selected direction; the latch is visible three clock edges after the input changes. The latch stays set after the input returns. A transition in the other direction latches nothing.
- R6: Writing the acknowledge register clears the latch of every pin whose data bit is 1. Bits written as 0 leave their latches unchanged.
- R7: A disabled pin never shows as pending and never latches. Writing its enable bit to 0 discards its latch. Changing trigger kind or polarity while a pin is disabled and then enabling it raises no event.
- R8: After an edge event, inverting the pin's polarity bit lets the opposite transition be captured as a new event, so both edges of a pulse can be observed.
- R9: `irq_shared_o` is the OR of the pending bits of every port except the last. It is 0 when only pins of the last port are pending.
- R10: `irq_pin_o[b]` is the pending bit b of the last port and is unaffected by the other ports.
- R11: When a matching transition and an acknowledge of the same pin take effect on the same clock edge, the pin ends up pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | PORTS*PINS | Asynchronous pin inputs, port-major |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_port_i | input | PORT_W | Port selected by a write |
| cfg_sel_i | input | 2 | Register selected by a write (kind, polarity, enable, acknowledge) |
| cfg_data_i | input | PINS | Write data, one bit per pin |
| stat_port_i | input | PORT_W | Port whose status is read |
| stat_data_o | output | PINS | Pending and enabled pins of the selected port |
| irq_shared_o | output | 1 | Combined request of all ports but the last |
| irq_pin_o | output | PINS | One request per pin of the last port |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge as a new matching transition. The event reaches the latch only after the synchroniser and the previous-sample register. The stimulus changes the pin on a falling edge and lets exactly two rising edges pass. It then issues the acknowledge write so that it is sampled on the third edge, the one on which the latch sets. A sweep over every pin of every port in all four trigger modes also reconfigures each pin while it is disabled and with its input at an arbitrary level. This exercises the rule that reconfiguration must not create an event.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Register selector of the configuration write port
    typedef enum logic [1:0] {
        SEL_KIND = 2'd0,
        SEL_POL  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_ACK  = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t stage_d, stage_q;

    always_comb begin
        stage_d        = stage_q;
        stage_d.meta   = async_i;
        stage_d.stable = stage_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q.stable;

endmodule

// File: rtl/port_detect.sv
module port_detect
    import pin_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] sync_i,
    input  logic            we_i,
    input  cfg_sel_e        sel_i,
    input  logic [PINS-1:0] wdata_i,
    output logic [PINS-1:0] status_o
);

    typedef struct packed {
        logic [PINS-1:0] edge_mode;  // 1 = transition, 0 = level
        logic [PINS-1:0] pol;        // 1 = high / rising
        logic [PINS-1:0] en;
        logic [PINS-1:0] latch;      // captured transitions
        logic [PINS-1:0] prev;       // previous synchronised sample
    } port_state_t;

    port_state_t st_d, st_q;

    logic [PINS-1:0] rise_w, fall_w, hit_w, ack_w, level_w;

    always_comb begin
        st_d    = st_q;
        rise_w  = sync_i & ~st_q.prev;
        fall_w  = ~sync_i & st_q.prev;
        hit_w   = st_q.en & st_q.edge_mode &
                  ((st_q.pol & rise_w) | (~st_q.pol & fall_w));
        ack_w   = '0;
        level_w = ~st_q.edge_mode & ~(sync_i ^ st_q.pol);

        st_d.prev = sync_i;
        if (we_i) begin
            unique case (sel_i)
                SEL_KIND: st_d.edge_mode = wdata_i;
                SEL_POL:  st_d.pol       = wdata_i;
                SEL_EN:   st_d.en        = wdata_i;
                SEL_ACK:  ack_w          = wdata_i;
                default:  ;
            endcase
        end
        // a new event wins over an acknowledge on the same edge;
        // disabled or level-mode pins hold no latch
        st_d.latch = ((st_q.latch & ~ack_w) | hit_w) & st_d.en & st_d.edge_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.en & ((st_q.edge_mode & st_q.latch) | level_w);

    a_r7_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~st_q.en) == '0));

    a_r7_no_latch_while_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.latch & ~$past(st_q.en)) == '0));

    a_r5_latch_needs_transition: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.latch & ~$past(st_q.latch) & ~$past(sync_i ^ st_q.prev)) == '0));

    a_r6_ack_clears_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_ACK) |=>
        ((st_q.latch & $past(wdata_i & ~(sync_i ^ st_q.prev))) == '0));

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pin_irq_pkg::*;
#(
    parameter int PORTS  = 3,
    parameter int PINS   = 8,
    parameter int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PORTS*PINS-1:0] pins_i,
    input  logic                  cfg_we_i,
    input  logic [PORT_W-1:0]     cfg_port_i,
    input  logic [1:0]            cfg_sel_i,
    input  logic [PINS-1:0]       cfg_data_i,
    input  logic [PORT_W-1:0]     stat_port_i,
    output logic [PINS-1:0]       stat_data_o,
    output logic                  irq_shared_o,
    output logic [PINS-1:0]       irq_pin_o
);

    localparam int LINES       = PORTS * PINS;
    localparam int DIRECT_PORT = PORTS - 1;

    logic [LINES-1:0] sync_w;
    logic [PINS-1:0]  status_w [PORTS];
    logic [PORTS-1:0] port_we_w;

    pin_sync #(.WIDTH(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (sync_w)
    );

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        assign port_we_w[g] = cfg_we_i && (cfg_port_i == PORT_W'(g));

        port_detect #(.PINS(PINS)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_w[g*PINS +: PINS]),
            .we_i     (port_we_w[g]),
            .sel_i    (cfg_sel_e'(cfg_sel_i)),
            .wdata_i  (cfg_data_i),
            .status_o (status_w[g])
        );
    end

    always_comb begin
        stat_data_o  = '0;
        irq_shared_o = 1'b0;
        for (int i = 0; i < PORTS; i++) begin
            if (stat_port_i == PORT_W'(i)) begin
                stat_data_o = status_w[i];
            end
            if (i != DIRECT_PORT) begin
                irq_shared_o = irq_shared_o | (|status_w[i]);
            end
        end
        irq_pin_o = status_w[DIRECT_PORT];
    end

endmodule

// File: tb/tb_pin_event_irq.sv
module tb_pin_event_irq;

    localparam int PORTS = 3;
    localparam int PINS  = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [PORTS*PINS-1:0] pins_i = '0;
    logic                  cfg_we_i = 1'b0;
    logic [1:0]            cfg_port_i = '0;
    logic [1:0]            cfg_sel_i = '0;
    logic [PINS-1:0]       cfg_data_i = '0;
    logic [1:0]            stat_port_i = '0;
    logic [PINS-1:0]       stat_data_o;
    logic                  irq_shared_o;
    logic [PINS-1:0]       irq_pin_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_event_irq #(.PORTS(PORTS), .PINS(PINS)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_port_i   (cfg_port_i),
        .cfg_sel_i    (cfg_sel_i),
        .cfg_data_i   (cfg_data_i),
        .stat_port_i  (stat_port_i),
        .stat_data_o  (stat_data_o),
        .irq_shared_o (irq_shared_o),
        .irq_pin_o    (irq_pin_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int port, input int sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we_i   = 1'b1;
        cfg_port_i = 2'(port);
        cfg_sel_i  = 2'(sel);
        cfg_data_i = data;
        @(negedge clk);
        cfg_we_i   = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic status_of(input int port, output logic [7:0] s);
        stat_port_i = 2'(port);
        #0.1;
        s = stat_data_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        // R1: reset state, during and after reset
        for (int p = 0; p < PORTS; p++) begin
            status_of(p, s);
            chk("R1 status in reset", 32'(s), 0);
        end
        rst_n = 1'b1;
        pins_i = '1;
        settle();
        for (int p = 0; p < PORTS; p++) begin
            status_of(p, s);
            chk("R1 status after reset, pins high", 32'(s), 0);
        end
        chk("R1 shared line", 32'(irq_shared_o), 0);
        chk("R1 per-pin lines", 32'(irq_pin_o), 0);

        // R2 R3 R4 R5 R6 R7 R9 R10: sweep every pin in every mode
        for (int p = 0; p < PORTS; p++) begin
            for (int b = 0; b < PINS; b++) begin
                for (int m = 0; m < 4; m++) begin
                    bit e;
                    bit v;
                    logic [7:0] idle_v;
                    logic [7:0] bitm;
                    logic [7:0] vec;
                    e      = m[1];
                    v      = m[0];
                    idle_v = v ? 8'h00 : 8'hFF;
                    bitm   = 8'(1 << b);
                    vec    = idle_v;
                    vec[b] = e ? v : ~v;
                    pins_i = '0;
                    pins_i[p*PINS +: PINS] = vec;
                    wr(p, 2, 8'h00);
                    wr(p, 0, e ? 8'hFF : 8'h00);
                    wr(p, 1, v ? 8'hFF : 8'h00);
                    settle();
                    wr(p, 3, 8'hFF);
                    wr(p, 2, bitm);
                    settle();
                    status_of(p, s);
                    chk("R7 reconfigure while disabled gives no event", 32'(s), 0);
                    if (e) begin
                        pins_i[p*PINS + b] = ~v;
                        settle();
                        status_of(p, s);
                        chk("R5 opposite transition ignored", 32'(s), 0);
                    end
                    pins_i[p*PINS + b] = v;
                    settle();
                    status_of(p, s);
                    chk("R2 R4 R5 active pin pending", 32'(s), 32'(bitm));
                    if (p < PORTS - 1) begin
                        chk("R9 shared line set", 32'(irq_shared_o), 1);
                        chk("R10 per-pin lines idle", 32'(irq_pin_o), 0);
                    end else begin
                        chk("R9 shared line idle", 32'(irq_shared_o), 0);
                        chk("R10 per-pin line set", 32'(irq_pin_o), 32'(bitm));
                    end
                    pins_i[p*PINS + b] = ~v;
                    settle();
                    status_of(p, s);
                    chk("R4 R5 after input returns", 32'(s), e ? 32'(bitm) : 0);
                    if (e) begin
                        wr(p, 3, ~bitm);
                        status_of(p, s);
                        chk("R6 zero bits leave latch", 32'(s), 32'(bitm));
                        wr(p, 3, bitm);
                        status_of(p, s);
                        chk("R6 one bit clears latch", 32'(s), 0);
                    end else begin
                        pins_i[p*PINS + b] = v;
                        settle();
                        wr(p, 3, bitm);
                        status_of(p, s);
                        chk("R4 acknowledge has no effect on level", 32'(s), 32'(bitm));
                        pins_i[p*PINS + b] = ~v;
                        settle();
                    end
                    wr(p, 2, 8'h00);
                end
            end
        end
        pins_i = '0;
        settle();

        // R8: flip polarity after each event to catch both edges
        wr(0, 0, 8'h08);
        wr(0, 1, 8'h08);
        wr(0, 2, 8'h08);
        settle();
        pins_i[3] = 1'b1;
        settle();
        status_of(0, s);
        chk("R8 rising captured", 32'(s), 32'h08);
        wr(0, 1, 8'h00);
        wr(0, 3, 8'h08);
        status_of(0, s);
        chk("R8 cleared before falling", 32'(s), 0);
        pins_i[3] = 1'b0;
        settle();
        status_of(0, s);
        chk("R8 falling captured", 32'(s), 32'h08);

        // R7: disabling discards a latched event
        wr(0, 2, 8'h00);
        wr(0, 2, 8'h08);
        status_of(0, s);
        chk("R7 disable discards latch", 32'(s), 0);
        wr(0, 2, 8'h00);

        // R11: event and acknowledge on the same edge
        wr(1, 0, 8'h04);
        wr(1, 1, 8'h04);
        wr(1, 2, 8'h04);
        settle();
        @(negedge clk);
        pins_i[PINS + 2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(1, 3, 8'h04);
        status_of(1, s);
        chk("R11 event wins over acknowledge", 32'(s), 32'h04);
        wr(1, 3, 8'h04);
        status_of(1, s);
        chk("R11 later acknowledge clears", 32'(s), 0);
        wr(1, 2, 8'h00);

        // R9: OR across the shared ports, last port excluded
        wr(0, 0, 8'h00); wr(0, 1, 8'h01); wr(0, 2, 8'h01);
        wr(1, 0, 8'h00); wr(1, 1, 8'h80); wr(1, 2, 8'h80);
        wr(2, 0, 8'h00); wr(2, 1, 8'h01); wr(2, 2, 8'h01);
        pins_i = '0;
        pins_i[0] = 1'b1;
        pins_i[PINS + 7] = 1'b1;
        settle();
        chk("R9 two ports pending", 32'(irq_shared_o), 1);
        pins_i[0] = 1'b0;
        settle();
        chk("R9 one port pending", 32'(irq_shared_o), 1);
        pins_i[PINS + 7] = 1'b0;
        pins_i[2*PINS] = 1'b1;
        settle();
        chk("R9 only last port pending", 32'(irq_shared_o), 0);
        chk("R10 last port line", 32'(irq_pin_o), 32'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule